// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block resolves read-after-write dependences for the two ALU operands of a five-stage in-order integer pipeline. The instruction now executing names two source registers. The instruction one step ahead (in the memory stage) and the instruction two steps ahead (in the write-back stage) each present a destination index, a flag saying whether they really write a register, and the value they will write. For each operand the unit decides whether a newer value than the register-file read exists. It raises a hazard select and supplies that value. It also performs the final operand selection, so the ALU receives the correct operand directly.

The unit is purely combinational and holds no state, so every output is valid in the same cycle as its inputs. When both later stages write the same register that an operand reads, the memory-stage value is used, because it is the younger result. Register index zero is hard-wired to zero and is never forwarded.

Top module: `fwd_unit`

## Requirements
- R1: When the memory-stage instruction writes a register (write flag 1), its destination index is nonzero and equals operand A's source index, `haz_a` is 1 and `fwd_a` equals `mem_val`.
- R2: The same rule as R1 applies to operand B, using `src_b`, `haz_b` and `fwd_b`.
- R3: When the memory stage does not match an operand but the write-back stage does, under the same rules (write flag 1, nonzero equal index), that operand's hazard is 1 and its forwarded value equals `wb_val`.
- R4: When both stages match the same operand, the forwarded value is `mem_val`.
- R5: A stage whose write flag is 0 never causes a match, whatever its destination index.
- R6: A source index of zero never raises a hazard, even when a writing stage targets register zero.
- R7: When an operand has no match, its hazard is 0, its forwarded value is all zeros and its operand output equals its register-file value.
- R8: When an operand's hazard is 1, its operand output equals its forwarded value.
- R9: The two operands are resolved independently. Equal source indices give identical decisions, and one operand can forward from one stage while the other forwards from the other stage.
- R10: Outputs follow inputs in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | RW | Source register index of operand A (execute stage) |
| src_b | input | RW | Source register index of operand B (execute stage) |
| rf_a | input | DW | Register-file read value for operand A |
| rf_b | input | DW | Register-file read value for operand B |
| mem_dst | input | RW | Destination index of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_val | input | DW | Memory-stage result value |
| wb_dst | input | RW | Destination index of the write-back-stage instruction |
| wb_wr | input | 1 | Write-back-stage instruction writes a register |
| wb_val | input | DW | Write-back-stage result value |
| fwd_a | output | DW | Forwarded value for operand A (zero when no hazard) |
| fwd_b | output | DW | Forwarded value for operand B (zero when no hazard) |
| haz_a | output | 1 | Operand A uses the forwarded value |
| haz_b | output | 1 | Operand B uses the forwarded value |
| opnd_a | output | DW | Resolved ALU operand A |
| opnd_b | output | DW | Resolved ALU operand B |

## Verification
The immediate assertions are re-evaluated whenever the inputs change. They cover the selection rules inside each operand path: memory-stage priority, the idle output values, and an operand output that follows its forwarded value under a hazard. At the top level they also check that index zero and cleared write flags never raise a hazard. Some behaviours can be shown only by the bench's scenarios, because they depend on a chosen sequence of index collisions. These are write-back-only forwarding, both stages writing the same register, both operands sharing one source, and each operand forwarding from a different stage. The bench also checks same-cycle response, because it changes inputs and samples half a period later.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    // Which producer supplies an operand.
    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_MEM = 2'd1,
        SRC_WB  = 2'd2
    } fwd_src_e;
endpackage

// File: rtl/fwd_stage_match.sv
module fwd_stage_match #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] dst,
    input  logic          wr,
    output logic          hit
);
    localparam logic [RW-1:0] ZERO_IDX = '0;

    always_comb begin
        hit = wr && (dst != ZERO_IDX) && (dst == src);
    end
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          hit_mem,
    input  logic          hit_wb,
    input  logic [DW-1:0] mem_val,
    input  logic [DW-1:0] wb_val,
    input  logic [DW-1:0] rf_val,
    output logic [DW-1:0] fwd_val,
    output logic          hazard,
    output logic [DW-1:0] opnd
);
    typedef struct packed {
        fwd_src_e      src;
        logic [DW-1:0] val;
        logic          haz;
        logic [DW-1:0] opnd;
    } sel_t;

    sel_t sel_d;

    always_comb begin
        sel_d = '0;
        if (hit_mem)
            sel_d.src = SRC_MEM;
        else if (hit_wb)
            sel_d.src = SRC_WB;
        else
            sel_d.src = SRC_RF;

        unique case (sel_d.src)
            SRC_MEM: sel_d.val = mem_val;
            SRC_WB:  sel_d.val = wb_val;
            default: sel_d.val = '0;
        endcase
        sel_d.haz  = (sel_d.src != SRC_RF);
        sel_d.opnd = sel_d.haz ? sel_d.val : rf_val;
    end

    assign fwd_val = sel_d.val;
    assign hazard  = sel_d.haz;
    assign opnd    = sel_d.opnd;

    always_comb begin
        // R4: the younger producer wins
        a_r4_mem_priority: assert (!hit_mem || (fwd_val == mem_val && hazard))
            else $error("a_r4_mem_priority");
        // R7: idle operand passes the register file through
        a_r7_idle_pass: assert (hazard || (opnd == rf_val && fwd_val == '0))
            else $error("a_r7_idle_pass");
        // R8: hazard steers the operand to the bypass value
        a_r8_opnd_follow: assert (!hazard || opnd == fwd_val)
            else $error("a_r8_opnd_follow");
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
    parameter int RW = 5,
    parameter int DW = 32
) (
    input  logic [RW-1:0] src_a,
    input  logic [RW-1:0] src_b,
    input  logic [DW-1:0] rf_a,
    input  logic [DW-1:0] rf_b,
    input  logic [RW-1:0] mem_dst,
    input  logic          mem_wr,
    input  logic [DW-1:0] mem_val,
    input  logic [RW-1:0] wb_dst,
    input  logic          wb_wr,
    input  logic [DW-1:0] wb_val,
    output logic [DW-1:0] fwd_a,
    output logic [DW-1:0] fwd_b,
    output logic          haz_a,
    output logic          haz_b,
    output logic [DW-1:0] opnd_a,
    output logic [DW-1:0] opnd_b
);
    localparam int NOPS = 2;

    logic [NOPS-1:0][RW-1:0] src_v;
    logic [NOPS-1:0][DW-1:0] rf_v;
    logic [NOPS-1:0][DW-1:0] fwd_v;
    logic [NOPS-1:0][DW-1:0] opnd_v;
    logic [NOPS-1:0]         haz_v;
    logic [NOPS-1:0]         hit_mem_v;
    logic [NOPS-1:0]         hit_wb_v;

    assign src_v = {src_b, src_a};
    assign rf_v  = {rf_b, rf_a};

    for (genvar i = 0; i < NOPS; i++) begin : g_op
        fwd_stage_match #(.RW(RW)) u_mem_cmp (
            .src(src_v[i]), .dst(mem_dst), .wr(mem_wr), .hit(hit_mem_v[i])
        );
        fwd_stage_match #(.RW(RW)) u_wb_cmp (
            .src(src_v[i]), .dst(wb_dst), .wr(wb_wr), .hit(hit_wb_v[i])
        );
        fwd_operand_sel #(.DW(DW)) u_sel (
            .hit_mem(hit_mem_v[i]),
            .hit_wb (hit_wb_v[i]),
            .mem_val(mem_val),
            .wb_val (wb_val),
            .rf_val (rf_v[i]),
            .fwd_val(fwd_v[i]),
            .hazard (haz_v[i]),
            .opnd   (opnd_v[i])
        );
    end

    assign fwd_a  = fwd_v[0];
    assign fwd_b  = fwd_v[1];
    assign haz_a  = haz_v[0];
    assign haz_b  = haz_v[1];
    assign opnd_a = opnd_v[0];
    assign opnd_b = opnd_v[1];

    always_comb begin
        // R6: register zero never forwards
        a_r6_zero_a: assert (src_a != '0 || !haz_a) else $error("a_r6_zero_a");
        a_r6_zero_b: assert (src_b != '0 || !haz_b) else $error("a_r6_zero_b");
        // R5: no writing stage means no hazard
        a_r5_no_writer: assert (mem_wr || wb_wr || (!haz_a && !haz_b))
            else $error("a_r5_no_writer");
        // R9: equal sources resolve identically
        a_r9_same_src: assert (src_a != src_b || (haz_a == haz_b && fwd_a == fwd_b))
            else $error("a_r9_same_src");
    end
endmodule

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
    localparam int RW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [RW-1:0] src_a, src_b, mem_dst, wb_dst;
    logic [DW-1:0] rf_a, rf_b, mem_val, wb_val;
    logic          mem_wr, wb_wr;
    logic [DW-1:0] fwd_a, fwd_b, opnd_a, opnd_b;
    logic          haz_a, haz_b;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    fwd_unit #(.RW(RW), .DW(DW)) u_fwd_unit (
        .src_a(src_a), .src_b(src_b), .rf_a(rf_a), .rf_b(rf_b),
        .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_val(mem_val),
        .wb_dst(wb_dst), .wb_wr(wb_wr), .wb_val(wb_val),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .haz_a(haz_a), .haz_b(haz_b),
        .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    // Behavioural reference: which producer an operand reads from.
    // 0 = register file, 1 = memory stage, 2 = write-back stage.
    function automatic int pick(input int src);
        if (src == 0) return 0;
        if (mem_wr && int'(mem_dst) == src) return 1;
        if (wb_wr && int'(wb_dst) == src) return 2;
        return 0;
    endfunction

    task automatic check_op(input string name, input int src,
                            input logic [DW-1:0] rf, input logic h,
                            input logic [DW-1:0] f, input logic [DW-1:0] o);
        int p;
        logic [DW-1:0] ef, eo;
        logic eh;
        string tag;
        p  = pick(src);
        eh = (p != 0);
        ef = (p == 1) ? mem_val : (p == 2) ? wb_val : '0;
        eo = eh ? ef : rf;
        if (src == 0) tag = "R6";
        else if (p == 1 && wb_wr && int'(wb_dst) == src) tag = "R4";
        else if (p == 1) tag = (name == "A") ? "R1" : "R2";
        else if (p == 2) tag = "R3";
        else if ((int'(mem_dst) == src && !mem_wr) || (int'(wb_dst) == src && !wb_wr)) tag = "R5";
        else tag = "R7";
        n_run++;
        if (h !== eh || f !== ef || o !== eo) begin
            n_fail++;
            $display("FAIL %s/R8/R10 op %s: haz=%0b fwd=%h opnd=%h expected haz=%0b fwd=%h opnd=%h",
                     tag, name, h, f, o, eh, ef, eo);
        end
    endtask

    // Apply a vector shortly after a rising edge; compare at the falling edge.
    task automatic apply(input int sa, input int sb, input int md, input bit mw,
                         input int wd, input bit ww);
        @(posedge clk);
        #1;
        src_a = RW'(sa); src_b = RW'(sb);
        mem_dst = RW'(md); mem_wr = mw;
        wb_dst = RW'(wd); wb_wr = ww;
        rf_a = $urandom; rf_b = $urandom;
        mem_val = $urandom; wb_val = $urandom;
        @(negedge clk);
        check_op("A", sa, rf_a, haz_a, fwd_a, opnd_a);
        check_op("B", sb, rf_b, haz_b, fwd_b, opnd_b);
    endtask

    initial begin
        src_a = '0; src_b = '0; mem_dst = '0; wb_dst = '0;
        mem_wr = 0; wb_wr = 0;
        rf_a = 32'h1111_0000; rf_b = 32'h2222_0000;
        mem_val = 32'hAAAA_AAAA; wb_val = 32'h5555_5555;
        @(negedge clk);
        // Idle state: no writer, operands pass through (R7)
        check_op("A", 0, rf_a, haz_a, fwd_a, opnd_a);
        check_op("B", 0, rf_b, haz_b, fwd_b, opnd_b);

        apply(3, 7, 3, 1, 9, 1);      // R1: A from memory stage
        apply(4, 8, 8, 1, 2, 1);      // R2: B from memory stage
        apply(6, 12, 1, 1, 6, 1);     // R3: A from write-back only
        apply(10, 10, 10, 1, 10, 1);  // R4 and R9: both stages, same source
        apply(5, 5, 5, 0, 5, 0);      // R5: writers disabled
        apply(5, 9, 5, 0, 5, 1);      // R5 then R3 fall-through
        apply(0, 0, 0, 1, 0, 1);      // R6: register zero
        apply(11, 13, 14, 1, 15, 1);  // R7: no match
        apply(20, 21, 21, 1, 20, 1);  // R9: A from wb, B from mem
        apply(31, 31, 31, 1, 30, 1);  // R9: shared source, top index
        apply(17, 18, 2, 1, 3, 0);    // R7

        for (int k = 0; k < 400; k++) begin
            apply($urandom_range(0, 7), $urandom_range(0, 7),
                  $urandom_range(0, 7), $urandom_range(0, 1),
                  $urandom_range(0, 7), $urandom_range(0, 1));
        end
        done = 1;
    end

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        wait (done || cycles > 5000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule